// File: doc/BRIEF.md
# Double-Buffer Swap Controller

This block decides which of two framebuffers the renderer draws into and which one the display scans out. The two sides run on separate, unrelated clocks. The renderer always writes the back buffer and the display always reads the front buffer. Their roles are exchanged only at a vertical sync, and only once the renderer has reported that its frame is finished.

The renderer pulses `frame_done_i` when a frame is complete. It then stalls, with `render_hold_o` high, until `swap_ack_o` reports that the display has taken the new frame. The report crosses into the display clock through a toggle synchronizer. There it waits as a pending request until the next `vsync_i`. At that vsync the display flips its front index and sends an acknowledge back through a second toggle synchronizer.

A vsync that finds no finished frame leaves the current front buffer on screen. A single index bit per domain selects between two base addresses that are set by parameters.

Top module: `double_buffer_swap`

## Requirements
- R1: After reset both domains report `BUF0_BASE` as front and `BUF1_BASE` as back, with `render_hold_o` and `swap_ack_o` low.
- R2: A `frame_done_i` pulse while the renderer is not held raises `render_hold_o` on the next graphics clock edge.
- R3: A `vsync_i` cycle with no finished frame pending leaves the display front and back bases unchanged, and no `swap_ack_o` follows.
- R4: A `vsync_i` cycle with a finished frame pending (including one arriving in that very cycle) exchanges the display front and back bases on the next display clock edge.
- R5: `swap_ack_o` is a single-cycle pulse that occurs only while the renderer is held. In the same cycle `render_hold_o` is low and the graphics front and back bases are exchanged.
- R6: A `frame_done_i` pulse while `render_hold_o` is high is ignored. It produces no second exchange at a later vsync.
- R7: The display front base never changes except on the clock edge that follows a `vsync_i` cycle.
- R8: Each accepted frame causes exactly one exchange in each domain, even when `vsync_i` is held high across many cycles.
- R9: Once an exchange has been acknowledged, the graphics domain's front and back bases equal those of the display domain.
- R10: In both domains the front and back bases are always different, and each is either `BUF0_BASE` or `BUF1_BASE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gfx_clk | input | 1 | Graphics domain clock |
| gfx_rst_n | input | 1 | Graphics domain synchronous reset, active low |
| frame_done_i | input | 1 | Renderer finished its frame (one-cycle pulse) |
| render_hold_o | output | 1 | Renderer must not write while high |
| swap_ack_o | output | 1 | One-cycle pulse: exchange done, next frame may start |
| gfx_front_base_o | output | ADDR_W | Front buffer base as seen by the graphics domain |
| gfx_back_base_o | output | ADDR_W | Back buffer base, the renderer's write target |
| disp_clk | input | 1 | Display domain clock |
| disp_rst_n | input | 1 | Display domain synchronous reset, active low |
| vsync_i | input | 1 | Vertical sync, high for one or more display cycles |
| disp_front_base_o | output | ADDR_W | Buffer base currently scanned out |
| disp_back_base_o | output | ADDR_W | Buffer base not being scanned out |

## Verification
Two events can fall in the same display cycle: a frame-done request arriving from the synchronizer and a vsync. In that case the exchange must still happen, and happen once. The bench provokes this by issuing a single-cycle vsync at a range of display-cycle offsets after each frame-done, so that one offset lands on the arrival cycle. It also holds vsync high for a long window while a frame-done crosses. Each case is judged by counting the exchanges and acknowledges in both domains, which must be exactly one per accepted frame.

// File: rtl/swap_pkg.sv
// Shared definitions for the double-buffer swap controller.
// Assumes: exactly two framebuffers, selected by a one-bit index.
package swap_pkg;

    // Renderer-side handshake state.
    typedef enum logic {
        ST_RENDER = 1'b0,   // renderer owns the back buffer
        ST_HOLD   = 1'b1    // frame submitted, waiting for the exchange
    } gfx_state_e;

    // Width of a framebuffer index.
    localparam int unsigned IDX_W = 1;

endpackage

// File: rtl/pulse_xing.sv
// Carries a single-cycle pulse from one clock domain to another.
// The source pulse flips a toggle register. The destination passes the toggle
// through SYNC_STAGES flip-flops and emits a one-cycle pulse on each change.
// Assumes: source pulses are spaced further apart than the round trip of the
// synchronizer, which the swap handshake guarantees. Each side has its own
// synchronous active-low reset, and both resets overlap at start-up.
module pulse_xing #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse_i,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse_o
);

    logic                   src_toggle;
    logic [SYNC_STAGES-1:0] dst_sync;
    logic                   dst_last;

    // Source: flip the toggle once per request pulse.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            src_toggle <= 1'b0;
        end else if (src_pulse_i) begin
            src_toggle <= ~src_toggle;
        end
    end

    // Destination: resynchronize the toggle and remember its settled value.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            dst_sync <= '0;
            dst_last <= 1'b0;
        end else begin
            dst_sync <= {dst_sync[SYNC_STAGES-2:0], src_toggle};
            dst_last <= dst_sync[SYNC_STAGES-1];
        end
    end

    // Destination: a change of the settled toggle is one request.
    always_comb begin
        dst_pulse_o = dst_sync[SYNC_STAGES-1] ^ dst_last;
    end

    // R8: one request yields a pulse of exactly one destination cycle
    // R8
    single_pulse_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_pulse_o |=> !dst_pulse_o);

endmodule

// File: rtl/base_select.sv
// Turns a one-bit front index into front and back base addresses.
// Assumes: two distinct bases, fixed by parameters.
module base_select #(
    parameter int unsigned       ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BUF0_BASE = '0,
    parameter logic [ADDR_W-1:0] BUF1_BASE = '1
) (
    input  logic              front_idx_i,
    output logic [ADDR_W-1:0] front_base_o,
    output logic [ADDR_W-1:0] back_base_o
);

    logic [ADDR_W-1:0] bases [2];

    // Table of buffer bases, one entry per buffer.
    always_comb begin
        bases[0] = BUF0_BASE;
        bases[1] = BUF1_BASE;
    end

    // Front is the indexed buffer, back is the other one.
    always_comb begin
        front_base_o = bases[front_idx_i];
        back_base_o  = bases[~front_idx_i];
    end

endmodule

// File: rtl/gfx_ctrl.sv
// Renderer-side half of the swap handshake.
// It accepts a frame-done pulse, holds the renderer and forwards one request.
// When the acknowledge returns it flips the local front index, releases the
// renderer and pulses swap_ack_o, all on the same clock edge.
// Assumes: ack_arrive_i is already synchronous to clk.
module gfx_ctrl
    import swap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done_i,
    input  logic ack_arrive_i,
    output logic req_pulse_o,
    output logic render_hold_o,
    output logic swap_ack_o,
    output logic front_idx_o
);

    gfx_state_e state;
    logic       front_idx;

    // A finished frame is accepted only while the renderer is free.
    always_comb begin
        req_pulse_o = frame_done_i && (state == ST_RENDER);
    end

    // Handshake state, local front index and acknowledge register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_RENDER;
            front_idx  <= 1'b0;
            swap_ack_o <= 1'b0;
        end else begin
            swap_ack_o <= 1'b0;
            case (state)
                ST_RENDER: if (frame_done_i) state <= ST_HOLD;
                ST_HOLD: begin
                    if (ack_arrive_i) begin
                        state      <= ST_RENDER;
                        front_idx  <= ~front_idx;
                        swap_ack_o <= 1'b1;
                    end
                end
                default: state <= ST_RENDER;
            endcase
        end
    end

    // Present the handshake state and index to the top.
    always_comb begin
        render_hold_o = (state == ST_HOLD);
        front_idx_o   = front_idx;
    end

    // R2
    hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && !render_hold_o) |=> render_hold_o);

    // R5
    ack_frees_renderer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_ack_o |-> (!render_hold_o && $past(render_hold_o)));

    // R5
    front_moves_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(front_idx) |-> swap_ack_o);

endmodule

// File: rtl/disp_ctrl.sv
// Display-side half of the swap handshake.
// It keeps a finished-frame request pending until vsync. At that vsync it
// flips the front index and emits an acknowledge pulse toward the renderer.
// Assumes: req_arrive_i is already synchronous to clk. A request arriving in
// the same cycle as vsync is served at that vsync.
module disp_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_i,
    input  logic req_arrive_i,
    output logic ack_pulse_o,
    output logic front_idx_o
);

    logic pending;
    logic front_idx;
    logic take;

    // An exchange is taken at vsync if a frame is waiting or arriving.
    always_comb begin
        take        = vsync_i && (pending || req_arrive_i);
        ack_pulse_o = take;
        front_idx_o = front_idx;
    end

    // Pending request and front index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            front_idx <= 1'b0;
        end else begin
            if (take) begin
                pending   <= 1'b0;
                front_idx <= ~front_idx;
            end else if (req_arrive_i) begin
                pending   <= 1'b1;
            end
        end
    end

    // R7
    front_only_at_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(front_idx) |-> $past(vsync_i));

    // R3
    idle_vsync_keeps_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_i && !pending && !req_arrive_i) |=> $stable(front_idx));

    // R4
    pending_vsync_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_i && (pending || req_arrive_i)) |=> !$stable(front_idx));

endmodule

// File: rtl/double_buffer_swap.sv
// Double-buffer swap controller between a graphics and a display clock domain.
// The renderer writes the back buffer and the display reads the front buffer.
// Roles are exchanged at vsync once a frame is finished, and the renderer is
// held until the exchange is acknowledged.
// Assumes: the two clocks are unrelated and each reset is synchronous to its
// own clock.
module double_buffer_swap #(
    parameter int unsigned       ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] BUF0_BASE   = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] BUF1_BASE   = 32'h0030_0000,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic              gfx_clk,
    input  logic              gfx_rst_n,
    input  logic              frame_done_i,
    output logic              render_hold_o,
    output logic              swap_ack_o,
    output logic [ADDR_W-1:0] gfx_front_base_o,
    output logic [ADDR_W-1:0] gfx_back_base_o,
    input  logic              disp_clk,
    input  logic              disp_rst_n,
    input  logic              vsync_i,
    output logic [ADDR_W-1:0] disp_front_base_o,
    output logic [ADDR_W-1:0] disp_back_base_o
);

    logic req_src;
    logic req_dst;
    logic ack_src;
    logic ack_dst;
    logic gfx_front_idx;
    logic disp_front_idx;

    gfx_ctrl u_gfx (
        .clk           (gfx_clk),
        .rst_n         (gfx_rst_n),
        .frame_done_i  (frame_done_i),
        .ack_arrive_i  (ack_dst),
        .req_pulse_o   (req_src),
        .render_hold_o (render_hold_o),
        .swap_ack_o    (swap_ack_o),
        .front_idx_o   (gfx_front_idx)
    );

    pulse_xing #(.SYNC_STAGES(SYNC_STAGES)) u_req_xing (
        .src_clk     (gfx_clk),
        .src_rst_n   (gfx_rst_n),
        .src_pulse_i (req_src),
        .dst_clk     (disp_clk),
        .dst_rst_n   (disp_rst_n),
        .dst_pulse_o (req_dst)
    );

    disp_ctrl u_disp (
        .clk          (disp_clk),
        .rst_n        (disp_rst_n),
        .vsync_i      (vsync_i),
        .req_arrive_i (req_dst),
        .ack_pulse_o  (ack_src),
        .front_idx_o  (disp_front_idx)
    );

    pulse_xing #(.SYNC_STAGES(SYNC_STAGES)) u_ack_xing (
        .src_clk     (disp_clk),
        .src_rst_n   (disp_rst_n),
        .src_pulse_i (ack_src),
        .dst_clk     (gfx_clk),
        .dst_rst_n   (gfx_rst_n),
        .dst_pulse_o (ack_dst)
    );

    base_select #(.ADDR_W(ADDR_W), .BUF0_BASE(BUF0_BASE), .BUF1_BASE(BUF1_BASE)) u_gfx_bases (
        .front_idx_i  (gfx_front_idx),
        .front_base_o (gfx_front_base_o),
        .back_base_o  (gfx_back_base_o)
    );

    base_select #(.ADDR_W(ADDR_W), .BUF0_BASE(BUF0_BASE), .BUF1_BASE(BUF1_BASE)) u_disp_bases (
        .front_idx_i  (disp_front_idx),
        .front_base_o (disp_front_base_o),
        .back_base_o  (disp_back_base_o)
    );

    // R10
    disp_bases_distinct_chk: assert property (@(posedge disp_clk) disable iff (!disp_rst_n)
        disp_front_base_o != disp_back_base_o);

endmodule

// File: tb/test_double_buffer_swap.sv
`timescale 1ns/1ps
module test_double_buffer_swap;

    localparam int unsigned       AW = 32;
    localparam logic [AW-1:0]     B0 = 32'h0000_0000;
    localparam logic [AW-1:0]     B1 = 32'h0030_0000;

    logic          gfx_clk = 1'b0;
    logic          disp_clk = 1'b0;
    logic          gfx_rst_n = 1'b0;
    logic          disp_rst_n = 1'b0;
    logic          frame_done_i = 1'b0;
    logic          vsync_i = 1'b0;
    logic          render_hold_o, swap_ack_o;
    logic [AW-1:0] gfx_front_base_o, gfx_back_base_o;
    logic [AW-1:0] disp_front_base_o, disp_back_base_o;

    int checks = 0;
    int fails  = 0;
    bit chk_en = 1'b0;

    // Behavioural reference state
    bit fd_q, vs_q;
    bit m_hold = 1'b0;
    bit m_gfront = 1'b0;
    logic [AW-1:0] last_dfront = B0;
    int disp_swaps = 0;
    int acks = 0;

    always #2.5  gfx_clk  = ~gfx_clk;   // 200 MHz
    always #3.85 disp_clk = ~disp_clk;  // unrelated display clock

    double_buffer_swap #(.ADDR_W(AW), .BUF0_BASE(B0), .BUF1_BASE(B1)) i_double_buffer_swap (
        .gfx_clk(gfx_clk), .gfx_rst_n(gfx_rst_n), .frame_done_i(frame_done_i),
        .render_hold_o(render_hold_o), .swap_ack_o(swap_ack_o),
        .gfx_front_base_o(gfx_front_base_o), .gfx_back_base_o(gfx_back_base_o),
        .disp_clk(disp_clk), .disp_rst_n(disp_rst_n), .vsync_i(vsync_i),
        .disp_front_base_o(disp_front_base_o), .disp_back_base_o(disp_back_base_o)
    );

    task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] base_of(input bit idx);
        return idx ? B1 : B0;
    endfunction

    // Capture inputs at the active edge
    always @(posedge gfx_clk)  fd_q <= frame_done_i;
    always @(posedge disp_clk) vs_q <= vsync_i;

    // Graphics-domain reference, compared every cycle
    always @(negedge gfx_clk) begin
        if (chk_en) begin
            if (swap_ack_o) begin
                // R5: acknowledge only while held
                check(m_hold, "R5 ack while held", {31'd0, swap_ack_o}, {31'd0, m_hold});
                m_hold = 1'b0;
                m_gfront = ~m_gfront;
                acks++;
            end else if (fd_q && !m_hold) begin
                m_hold = 1'b1;
            end
            // R2 / R5: hold level follows the reference
            check(render_hold_o == m_hold, "R2 hold", {31'd0, render_hold_o}, {31'd0, m_hold});
            // R5: bases exchanged with the acknowledge
            check(gfx_front_base_o == base_of(m_gfront), "R5 gfx front", gfx_front_base_o, base_of(m_gfront));
            // R10
            check(gfx_back_base_o == base_of(~m_gfront), "R10 gfx back", gfx_back_base_o, base_of(~m_gfront));
        end
    end

    // Display-domain reference, compared every cycle
    always @(negedge disp_clk) begin
        if (chk_en) begin
            if (disp_front_base_o != last_dfront) begin
                // R7: change only after a vsync cycle
                check(vs_q, "R7 front moved without vsync", disp_front_base_o, last_dfront);
                disp_swaps++;
            end
            last_dfront = disp_front_base_o;
            // R10
            check((disp_front_base_o != disp_back_base_o) &&
                  (disp_front_base_o == B0 || disp_front_base_o == B1),
                  "R10 disp bases", disp_back_base_o, disp_front_base_o);
        end
    end

    task automatic gfx_cycles(input int n);
        repeat (n) @(negedge gfx_clk);
    endtask

    task automatic disp_cycles(input int n);
        repeat (n) @(negedge disp_clk);
    endtask

    task automatic pulse_done();
        @(negedge gfx_clk); frame_done_i = 1'b1;
        @(negedge gfx_clk); frame_done_i = 1'b0;
    endtask

    task automatic pulse_vsync();
        @(negedge disp_clk); vsync_i = 1'b1;
        @(negedge disp_clk); vsync_i = 1'b0;
    endtask

    task automatic wait_settle();
        gfx_cycles(30);
    endtask

    // R9: both domains agree once the exchange has been acknowledged
    task automatic check_agree(input string tag);
        check(gfx_front_base_o == disp_front_base_o, tag, gfx_front_base_o, disp_front_base_o);
        check(gfx_back_base_o == disp_back_base_o, tag, gfx_back_base_o, disp_back_base_o);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int s0, a0;
        gfx_cycles(6);
        // R1: reset values
        check(gfx_front_base_o == B0, "R1 gfx front", gfx_front_base_o, B0);
        check(gfx_back_base_o == B1, "R1 gfx back", gfx_back_base_o, B1);
        check(disp_front_base_o == B0, "R1 disp front", disp_front_base_o, B0);
        check(disp_back_base_o == B1, "R1 disp back", disp_back_base_o, B1);
        check(!render_hold_o && !swap_ack_o, "R1 hold/ack", {30'd0, render_hold_o, swap_ack_o}, '0);
        @(negedge gfx_clk); gfx_rst_n = 1'b1;
        @(negedge disp_clk); disp_rst_n = 1'b1;
        chk_en = 1'b1;
        gfx_cycles(4);

        // R3: vsync with nothing pending
        for (int i = 0; i < 5; i++) begin pulse_vsync(); disp_cycles(3); end
        wait_settle();
        check(disp_swaps == 0 && acks == 0, "R3 idle vsync", disp_swaps, 0);
        check(disp_front_base_o == B0, "R3 front kept", disp_front_base_o, B0);

        // R2/R4: frame done, held until a vsync takes it
        pulse_done();
        wait_settle();
        check(render_hold_o == 1'b1, "R2 still held before vsync", {31'd0, render_hold_o}, 1);
        check(disp_swaps == 0, "R4 no exchange before vsync", disp_swaps, 0);
        pulse_vsync();
        wait_settle();
        check(disp_swaps == 1 && acks == 1, "R4 exchange at vsync", disp_swaps, 1);
        check(disp_front_base_o == B1, "R4 disp front", disp_front_base_o, B1);
        check_agree("R9 agree after first exchange");

        // R6: extra frame_done while held is ignored
        pulse_done();
        gfx_cycles(3);
        pulse_done();
        pulse_done();
        wait_settle();
        pulse_vsync();
        wait_settle();
        pulse_vsync();
        pulse_vsync();
        wait_settle();
        check(disp_swaps == 2 && acks == 2, "R6 ignored extra done", disp_swaps, 2);
        check_agree("R9 agree after R6");

        // R4: single vsync at a sweep of offsets after frame done
        for (int off = 0; off < 10; off++) begin
            s0 = disp_swaps; a0 = acks;
            pulse_done();
            disp_cycles(off);
            pulse_vsync();
            wait_settle();
            if (disp_swaps == s0) begin
                // vsync came before arrival: the next one takes it
                pulse_vsync();
                wait_settle();
            end
            check(disp_swaps == s0 + 1 && acks == a0 + 1, "R4 offset sweep", disp_swaps - s0, 1);
            check_agree("R9 agree in sweep");
        end

        // R8: vsync held high across the arrival
        s0 = disp_swaps; a0 = acks;
        @(negedge disp_clk); vsync_i = 1'b1;
        disp_cycles(3);
        pulse_done();
        disp_cycles(40);
        @(negedge disp_clk); vsync_i = 1'b0;
        wait_settle();
        check(disp_swaps == s0 + 1, "R8 one exchange under long vsync", disp_swaps - s0, 1);
        check(acks == a0 + 1, "R8 one ack under long vsync", acks - a0, 1);
        check_agree("R9 agree after long vsync");

        // R8: back-to-back frames each swap once
        s0 = disp_swaps;
        for (int f = 0; f < 4; f++) begin
            pulse_done();
            disp_cycles(6);
            pulse_vsync();
            wait_settle();
        end
        check(disp_swaps == s0 + 4, "R8 back-to-back frames", disp_swaps - s0, 4);
        check_agree("R9 agree at end");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule